// File: doc/BRIEF.md
# Digital Supply-Voltage Trim Loop

This block is the digital half of a closed-loop supply regulator. A replica of the chip's slowest path runs on the regulated rail, and a detector outside this block reports one bit per clock: whether the replica finished inside the clock period. The block holds a duty code and drives a PWM switching signal to an external buck stage, with the duty proportional to that code. On each tick of a programmable rate divider, it moves the code one step. The step lowers the rail when the replica passed and raises it when the replica failed. The loop therefore walks down to the lowest code at which the replica still passes, and then dithers one step around that point.

The verdict carries no magnitude, so every update changes the code by exactly one step, and the code saturates at both ends. The divider reload selects the loop rate. A reload of zero selects a slow default of 2000 cycles (62.5 kHz at 125 MHz), which sits well below the output filter's roll-off. A margin select picks how many extra delay stages the replica path carries, so that the settled rail sits further inside the passing region. The block forwards that selection to the replica delay line as a tap code, and changes it only on update ticks.

Top module: `vdd_trim_ctrl`

## Requirements
- R1: During and right after reset, `code_o` is 225 (the top of the range), `strobe_o` is 0 and `tap_o` is 0.
- R2: `code_o` changes only in the cycle in which `strobe_o` is high, and by at most one step per update.
- R3: Updates occur every N cycles, where N is the value of `div_i` taken at the previous update. A value of 0 selects N = 2000. `strobe_o` is high for exactly one cycle per update.
- R4: A verdict of 1 on `fast_i` (replica met the period) lowers the code by one, and a verdict of 0 raises it by one. The verdict used is the value of `fast_i` sampled two clock edges before the update edge.
- R5: `code_o` never leaves 61..225. It holds at 61 under a steady verdict of 1 and at 225 under a steady verdict of 0, and it never wraps.
- R6: With the replica passing at codes at or above a threshold T, the loop settles to dithering between T-1 and T.
- R7: `tap_o` takes the value of `margin_i` only on update ticks. With each tap step costing the replica six codes, margin 2 moves the settled dither up to T+11..T+12.
- R8: `pwm_o` is high while a free-running 8-bit counter is below the duty latched at the end of the previous 256-cycle period, so each period has `code_o` high cycles. `pwm_o` is low whenever `pwm_en_i` is 0.
- R9: Values of `fast_i` that are not sampled for an update have no effect on `code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_i | input | 1 | Replica verdict: 1 = met the period, 0 = missed it |
| div_i | input | 16 | Update interval in cycles; 0 selects the 2000-cycle default |
| margin_i | input | 2 | Requested number of extra replica delay stages |
| pwm_en_i | input | 1 | Enables the PWM drive |
| code_o | output | 8 | Duty code, 61..225 out of 256 |
| pwm_o | output | 1 | Switching drive for the buck stage |
| strobe_o | output | 1 | One-cycle pulse per update |
| tap_o | output | 2 | Extra-stage select for the replica delay line |

## Verification
The loop code, tap select and update strobe all change together, in the cycle after the divider's terminal-count edge. A verdict reaches the update logic two edges after it is sampled, and a new duty affects the PWM drive only from the next 256-cycle period. The bench's behavioural model advances on every rising edge with these latencies and is compared at the following falling edge, after all registers have settled. The directed checks on update intervals, direction, saturation, settling and PWM high time are timed from observed strobes, so they never depend on guessing the divider phase.

// File: rtl/vdd_trim_pkg.sv
`timescale 1ns/1ps
package vdd_trim_pkg;
  localparam int CODE_W_D      = 8;
  localparam int CODE_MIN_D    = 61;   // ~24% duty
  localparam int CODE_MAX_D    = 225;  // ~88% duty
  localparam int DIV_W_D       = 16;
  localparam int DIV_DEFAULT_D = 2000; // 62.5 kHz at 125 MHz
  localparam int MRG_W_D       = 2;
  localparam int SYNC_N_D      = 2;

  typedef enum logic {
    VERDICT_SLOW = 1'b0,
    VERDICT_MET  = 1'b1
  } verdict_e;
endpackage

// File: rtl/vtc_sync.sv
`timescale 1ns/1ps
module vtc_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC_N-1:0] ff_q;

  for (genvar g = 0; g < SYNC_N; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= ff_q[g-1];
    end
  end

  assign q_o = ff_q[SYNC_N-1];
endmodule

// File: rtl/vtc_rate_div.sv
`timescale 1ns/1ps
module vtc_rate_div #(
  parameter int DIV_W       = 16,
  parameter int DIV_DEFAULT = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] DefReload = DIV_W'(DIV_DEFAULT);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] reload;

  assign reload = (div_i == '0) ? DefReload : div_i;
  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= reload - 1'b1;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/vtc_step.sv
`timescale 1ns/1ps
module vtc_step import vdd_trim_pkg::*; #(
  parameter int CODE_W   = 8,
  parameter int CODE_MIN = 61,
  parameter int CODE_MAX = 225,
  parameter int MRG_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              met_i,
  input  logic [MRG_W-1:0]  margin_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MRG_W-1:0]  tap_o,
  output logic              strobe_o
);
  localparam logic [CODE_W-1:0] CodeLo = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] CodeHi = CODE_W'(CODE_MAX);

  verdict_e verdict;
  assign verdict = verdict_e'(met_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o   <= CodeHi;  // power up fast, walk down
      tap_o    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= tick_i;
      if (tick_i) begin
        tap_o <= margin_i;
        if (verdict == VERDICT_MET) begin
          if (code_o > CodeLo) code_o <= code_o - 1'b1;
        end else begin
          if (code_o < CodeHi) code_o <= code_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vtc_pwm.sv
`timescale 1ns/1ps
module vtc_pwm #(
  parameter int CODE_W   = 8,
  parameter int CODE_MAX = 225
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pwm_o
);
  logic [CODE_W-1:0] pcnt_q;
  logic [CODE_W-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      duty_q <= CODE_W'(CODE_MAX);
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
      if (&pcnt_q) duty_q <= code_i;  // new duty only at period boundary
    end
  end

  assign pwm_o = en_i & (pcnt_q < duty_q);
endmodule

// File: rtl/vdd_trim_ctrl.sv
`timescale 1ns/1ps
module vdd_trim_ctrl import vdd_trim_pkg::*; #(
  parameter int CODE_W      = CODE_W_D,
  parameter int CODE_MIN    = CODE_MIN_D,
  parameter int CODE_MAX    = CODE_MAX_D,
  parameter int DIV_W       = DIV_W_D,
  parameter int DIV_DEFAULT = DIV_DEFAULT_D,
  parameter int MRG_W       = MRG_W_D,
  parameter int SYNC_N      = SYNC_N_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [MRG_W-1:0]  margin_i,
  input  logic              pwm_en_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pwm_o,
  output logic              strobe_o,
  output logic [MRG_W-1:0]  tap_o
);
  logic tick;
  logic met_sync;

  vtc_rate_div #(.DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  vtc_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fast_i), .q_o(met_sync)
  );

  vtc_step #(
    .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .MRG_W(MRG_W)
  ) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .met_i(met_sync),
    .margin_i(margin_i), .code_o(code_o), .tap_o(tap_o), .strobe_o(strobe_o)
  );

  vtc_pwm #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pwm_en_i), .code_i(code_o), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/vdd_trim_ctrl_chk.sv
`timescale 1ns/1ps
module vdd_trim_ctrl_chk #(
  parameter int CODE_W   = 8,
  parameter int CODE_MIN = 61,
  parameter int CODE_MAX = 225,
  parameter int MRG_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_en_i,
  input logic [CODE_W-1:0] code_o,
  input logic              pwm_o,
  input logic              strobe_o,
  input logic [MRG_W-1:0]  tap_o
);
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(code_o)); // R2

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (code_o == $past(code_o)) ||
                 ({1'b0, code_o} == {1'b0, $past(code_o)} + 1'b1) ||
                 ({1'b0, code_o} + 1'b1 == {1'b0, $past(code_o)})); // R2

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o >= CODE_W'(CODE_MIN)) && (code_o <= CODE_W'(CODE_MAX))); // R5

  AST_TAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(tap_o)); // R7

  AST_PWM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en_i |-> !pwm_o); // R8
endmodule

bind vdd_trim_ctrl vdd_trim_ctrl_chk #(
  .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .MRG_W(MRG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_en_i(pwm_en_i), .code_o(code_o),
  .pwm_o(pwm_o), .strobe_o(strobe_o), .tap_o(tap_o)
);

// File: tb/vdd_trim_ctrl_tb.sv
`timescale 1ns/1ps
module vdd_trim_ctrl_tb;
  localparam int LO = 61, HI = 225, DEF = 2000, THR = 100, TAP_COST = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fast_i = 1'b0;
  logic [15:0] div_i = '0;
  logic [1:0]  margin_i = '0;
  logic        pwm_en_i = 1'b1;
  logic [7:0]  code_o;
  logic        pwm_o, strobe_o;
  logic [1:0]  tap_o;

  logic fast_req = 1'b0;
  logic fb_mode  = 1'b0;
  string phase = "R1";
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  vdd_trim_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fast_i(fast_i), .div_i(div_i),
    .margin_i(margin_i), .pwm_en_i(pwm_en_i), .code_o(code_o),
    .pwm_o(pwm_o), .strobe_o(strobe_o), .tap_o(tap_o)
  );

  // replica stand-in: passes at or above THR plus the cost of the selected taps
  always @(negedge clk)
    fast_i <= fb_mode ? (int'(code_o) >= THR + TAP_COST * int'(tap_o)) : fast_req;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_s1, m_s2, m_code, m_tap, m_strb, m_pcnt, m_duty;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_s1 = 0; m_s2 = 0; m_code = HI; m_tap = 0;
      m_strb = 0; m_pcnt = 0; m_duty = HI;
    end else begin
      int reload;
      reload = (div_i == 0) ? DEF : int'(div_i);
      if (m_pcnt == 255) m_duty = m_code;
      m_pcnt = (m_pcnt + 1) % 256;
      if (m_cnt == 0) begin
        m_tap = int'(margin_i);
        if (m_s2 == 1) begin if (m_code > LO) m_code--; end
        else           begin if (m_code < HI) m_code++; end
        m_strb = 1;
        m_cnt = reload - 1;
      end else begin
        m_strb = 0;
        m_cnt--;
      end
      m_s2 = m_s1;
      m_s1 = int'(fast_i);
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_ni && !done) begin
      int pexp;
      pexp = (pwm_en_i && (m_pcnt < m_duty)) ? 1 : 0;
      chk(int'(code_o) == m_code, phase, "code_o vs model (R2 R4)", int'(code_o), m_code);
      chk(int'(strobe_o) == m_strb, phase, "strobe_o vs model (R3)", int'(strobe_o), m_strb);
      chk(int'(tap_o) == m_tap, phase, "tap_o vs model (R7)", int'(tap_o), m_tap);
      chk(int'(pwm_o) == pexp, phase, "pwm_o vs model (R8)", int'(pwm_o), pexp);
    end
  end

  task automatic drive_slot();
    @(posedge clk); #2;
  endtask

  task automatic wait_strobe();
    do begin @(negedge clk); #1; end while (!strobe_o);
  endtask

  task automatic measure_gap(output int g);
    wait_strobe();
    g = 0;
    do begin @(negedge clk); #1; g++; end while (!strobe_o);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    checks++; fails++;
    $display("FAIL R3 watchdog: actual=%0d expected=%0d cycles", 100000, 0);
    summary();
    $finish;
  end

  initial begin
    int g, c0, lo_seen, hi_seen, highs;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(code_o == 8'(HI), "R1", "code_o in reset", int'(code_o), HI);
    chk(strobe_o == 1'b0, "R1", "strobe_o in reset", int'(strobe_o), 0);
    chk(tap_o == 2'd0, "R1", "tap_o in reset", int'(tap_o), 0);
    drive_slot();
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(code_o == 8'(HI), "R1", "code_o after reset", int'(code_o), HI);

    // R3: default interval, then programmed 1 MHz interval
    phase = "R3";
    measure_gap(g);
    chk(g == DEF, "R3", "default update interval", g, DEF);
    drive_slot(); div_i = 16'd125;
    measure_gap(g);
    measure_gap(g);
    chk(g == 125, "R3", "programmed update interval", g, 125);

    // R8: PWM high time at steady code 225, then disabled
    phase = "R8";
    highs = 0;
    for (int i = 0; i < 256; i++) begin @(negedge clk); #1; highs += int'(pwm_o); end
    chk(highs == HI, "R8", "pwm high cycles per period", highs, HI);
    drive_slot(); pwm_en_i = 1'b0;
    highs = 0;
    for (int i = 0; i < 256; i++) begin @(negedge clk); #1; highs += int'(pwm_o); end
    chk(highs == 0, "R8", "pwm high cycles while disabled", highs, 0);
    drive_slot(); pwm_en_i = 1'b1;

    // R4: direction of steps
    phase = "R4";
    div_i = 16'd8; fast_req = 1'b1;
    wait_strobe(); wait_strobe(); wait_strobe();
    c0 = int'(code_o);
    wait_strobe();
    chk(int'(code_o) == c0 - 1, "R4", "verdict 1 lowers code", int'(code_o), c0 - 1);
    drive_slot(); fast_req = 1'b0;
    wait_strobe(); wait_strobe();
    c0 = int'(code_o);
    wait_strobe();
    chk(int'(code_o) == c0 + 1, "R4", "verdict 0 raises code", int'(code_o), c0 + 1);

    // R9: verdict glitches between samples are ignored
    phase = "R9";
    drive_slot(); div_i = 16'd16; fast_req = 1'b1;
    wait_strobe(); wait_strobe();
    c0 = int'(code_o);
    drive_slot(); fast_req = 1'b0;
    repeat (8) drive_slot();
    fast_req = 1'b1;
    wait_strobe();
    chk(int'(code_o) == c0 - 1, "R9", "unsampled 0 pulse ignored", int'(code_o), c0 - 1);
    drive_slot(); fast_req = 1'b0;
    wait_strobe(); wait_strobe();
    c0 = int'(code_o);
    drive_slot(); fast_req = 1'b1;
    repeat (8) drive_slot();
    fast_req = 1'b0;
    wait_strobe();
    chk(int'(code_o) == c0 + 1, "R9", "unsampled 1 pulse ignored", int'(code_o), c0 + 1);

    // R5: saturation at both ends
    phase = "R5";
    drive_slot(); div_i = 16'd2; fast_req = 1'b1;
    repeat (500) @(negedge clk);
    #1;
    chk(code_o == 8'(LO), "R5", "saturates at minimum", int'(code_o), LO);
    repeat (20) @(negedge clk);
    #1;
    chk(code_o == 8'(LO), "R5", "holds at minimum, no wrap", int'(code_o), LO);
    drive_slot(); fast_req = 1'b0;
    repeat (500) @(negedge clk);
    #1;
    chk(code_o == 8'(HI), "R5", "saturates at maximum", int'(code_o), HI);
    repeat (20) @(negedge clk);
    #1;
    chk(code_o == 8'(HI), "R5", "holds at maximum, no wrap", int'(code_o), HI);

    // R6: closed loop settles and dithers around THR
    phase = "R6";
    drive_slot(); div_i = 16'd8; fb_mode = 1'b1;
    repeat (1500) @(negedge clk);
    lo_seen = 255; hi_seen = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); #1;
      if (int'(code_o) < lo_seen) lo_seen = int'(code_o);
      if (int'(code_o) > hi_seen) hi_seen = int'(code_o);
    end
    chk(lo_seen == THR - 1, "R6", "settled low code", lo_seen, THR - 1);
    chk(hi_seen == THR, "R6", "settled high code", hi_seen, THR);

    // R7: margin adds replica stages, settled point moves up
    phase = "R7";
    drive_slot(); margin_i = 2'd2;
    @(negedge clk); #1;
    if (!strobe_o) chk(tap_o == 2'd0, "R7", "tap holds until tick", int'(tap_o), 0);
    repeat (600) @(negedge clk);
    #1;
    chk(tap_o == 2'd2, "R7", "tap follows margin", int'(tap_o), 2);
    lo_seen = 255; hi_seen = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); #1;
      if (int'(code_o) < lo_seen) lo_seen = int'(code_o);
      if (int'(code_o) > hi_seen) hi_seen = int'(code_o);
    end
    chk(lo_seen == THR + 2 * TAP_COST - 1, "R7", "guarded low code", lo_seen, THR + 11);
    chk(hi_seen == THR + 2 * TAP_COST, "R7", "guarded high code", hi_seen, THR + 12);

    done = 1;
    summary();
    $finish;
  end
endmodule